// File: doc/BRIEF.md
# Register-Mapped Packet FIFO Bridge

This block sits between a simple register bus and two word streams. On the receive side, words arrive on a valid/last stream and are written into a local store. Software sees nothing of a packet until its final word has been taken. Only then does the occupancy register jump by the packet's full word count, so a non-zero reading always means at least one complete packet is waiting. Software then drains the words, oldest first, through a single data read port.

On the transmit side, software writes the words of a packet one at a time into a transmit store. Those words stay put until software writes the packet length in bytes. That write releases the words onto a valid/ready output stream, with last marking the final word. Receive packets that are too short, too long, or that do not fit in the free space are discarded as a whole. The receive stream is never stalled.

Top module: `pkt_fifo_bridge`

## Requirements
- R1: After reset, the occupancy register reads zero and `tx_valid` is low.
- R2: A read at byte address 0x1C returns the committed word count in bits [8:0], with bits [31:9] always zero.
- R3: While a receive packet is still arriving, the occupancy value does not change. In the cycle after its last word is accepted, occupancy rises by the packet's word count.
- R4: A read at byte address 0x20 returns the oldest stored receive word, removes it, and lowers the occupancy by one.
- R5: A read at 0x20 while occupancy is zero returns zero and leaves the occupancy and the stored words unchanged.
- R6: A receive packet of fewer than 4 words is discarded whole and never counted.
- R7: A receive packet of more than 510 words is discarded whole and never counted. So is a packet that does not fit in the free space of the 511-word receive store.
- R8: A write at byte address 0x10 queues one transmit word. Queued words are not sent until a length is written at byte address 0x14, whose bits [11:0] hold the packet length in bytes.
- R9: After a length of L bytes is written, the transmit stream delivers ceil(L/4) queued words in write order. `tx_last` is high on the final word only, and the stream then goes idle.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R11: A length write of zero sends nothing and leaves the queued words waiting for a later length.
- R12: `rx_ready` is always high. Words of a discarded packet are consumed without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of 0x20 consumes a word) |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| rx_valid | input | 1 | Receive word present |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Final word of a receive packet |
| rx_ready | output | 1 | Receive accept (constant high) |
| tx_valid | output | 1 | Transmit word present |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of a transmit packet |
| tx_ready | input | 1 | Transmit accept from the sink |

## Verification
The bench probes occupancy one cycle before and one cycle after a packet's last word. A design that counted speculatively would show a partial count there. Short packets, packets over 510 words, and packets that exceed the free space left by a 510-word packet are each sent. A design that kept any of their words would show a raised count or stale words in the read stream. Reads of an empty port must return zero without moving the pointer; if they did move it, later data would come out shifted. On transmit, the bench writes the words and holds the length back, and it also writes a zero length. A block that sent on data presence, or that treated zero as a large length, would raise `tx_valid` early. Random back-pressure shows whether words are dropped, repeated, or change while stalled.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    localparam int DATA_W = 32;
    localparam int BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_TX_WORD = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_TX_LEN  = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_RX_OCC  = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_RX_WORD = 8'h20;

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [DATA_W-1:0] data;
    } beat_t;

    function automatic int unsigned words_of_bytes(input int unsigned nbytes);
        return (nbytes + 3) / 4;
    endfunction
endpackage

// File: rtl/pfb_ram.sv
module pfb_ram #(
    parameter int DEPTH = 512,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pfb_rx.sv
module pfb_rx
    import pfb_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int MIN_WORDS = 4,
    parameter int MAX_WORDS = 510,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(MAX_WORDS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             in_beat,
    input  logic              pop,
    output logic [AW-1:0]     occ,
    output logic [DATA_W-1:0] head,
    output logic              commit
);
    logic [AW-1:0] wr_ptr, com_ptr, rd_ptr, used_spec;
    logic [CW-1:0] pkt_cnt;
    logic          drop, take, has_space, do_pop, past_ok;

    assign used_spec = wr_ptr - rd_ptr;
    assign has_space = used_spec != AW'(DEPTH - 1);
    assign take      = in_beat.valid && !drop && has_space && (pkt_cnt < CW'(MAX_WORDS));
    assign commit    = in_beat.valid && in_beat.last && take &&
                       ((pkt_cnt + CW'(1)) >= CW'(MIN_WORDS));
    assign occ       = com_ptr - rd_ptr;
    assign do_pop    = pop && (occ != '0);

    pfb_ram #(.DEPTH(DEPTH), .W(DATA_W)) store_i (
        .clk  (clk),
        .we   (take),
        .waddr(wr_ptr),
        .wdata(in_beat.data),
        .raddr(rd_ptr),
        .rdata(head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            com_ptr <= '0;
            rd_ptr  <= '0;
            pkt_cnt <= '0;
            drop    <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (do_pop) rd_ptr <= rd_ptr + AW'(1);
            if (in_beat.valid) begin
                if (in_beat.last) begin
                    pkt_cnt <= '0;
                    drop    <= 1'b0;
                    if (commit) begin
                        wr_ptr  <= wr_ptr + AW'(1);
                        com_ptr <= wr_ptr + AW'(1);
                    end else begin
                        wr_ptr  <= com_ptr;
                    end
                end else if (take) begin
                    pkt_cnt <= pkt_cnt + CW'(1);
                    wr_ptr  <= wr_ptr + AW'(1);
                end else begin
                    drop    <= 1'b1;
                end
            end
        end
    end

    // R3: occupancy only rises in the cycle after a commit
    a_r3_rise_on_commit: assert property (@(posedge clk) disable iff (rst)
        (past_ok && occ > $past(occ)) |-> $past(commit));

    // R4: a pop of a non-empty store lowers occupancy by one
    a_r4_pop_decrements: assert property (@(posedge clk) disable iff (rst)
        (past_ok && pop && occ != '0 && !commit) |=> (occ == $past(occ) - AW'(1)));

    // R5: popping an empty store leaves it empty
    a_r5_idle_pop: assert property (@(posedge clk) disable iff (rst)
        (past_ok && pop && occ == '0 && !commit) |=> (occ == '0));
endmodule

// File: rtl/pfb_tx.sv
module pfb_tx
    import pfb_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int LQ_DEPTH = 4,
    parameter int LEN_W    = 12,
    localparam int AW  = $clog2(DEPTH),
    localparam int LQW = $clog2(LQ_DEPTH),
    localparam int RW  = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_val,
    output beat_t             out_beat,
    input  logic              out_ready
);
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [DATA_W-1:0] head;
    logic             full, nonempty, active, fire, load, len_ok;
    logic [RW-1:0]    rem;
    logic [LEN_W-1:0] lq [LQ_DEPTH];
    logic [LQW-1:0]   lq_wp, lq_rp;
    logic [LQW:0]     lq_cnt;
    logic             past_ok;

    assign full      = (wr_ptr - rd_ptr) == AW'(DEPTH - 1);
    assign nonempty  = wr_ptr != rd_ptr;
    assign len_ok    = len_wr && (len_val != '0) && (lq_cnt != (LQW+1)'(LQ_DEPTH));
    assign load      = !active && (lq_cnt != '0);

    assign out_beat.valid = active && nonempty;
    assign out_beat.data  = head;
    assign out_beat.last  = active && (rem == RW'(1));
    assign fire           = out_beat.valid && out_ready;

    pfb_ram #(.DEPTH(DEPTH), .W(DATA_W)) store_i (
        .clk  (clk),
        .we   (push && !full),
        .waddr(wr_ptr),
        .wdata(push_data),
        .raddr(rd_ptr),
        .rdata(head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            lq_wp   <= '0;
            lq_rp   <= '0;
            lq_cnt  <= '0;
            active  <= 1'b0;
            rem     <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (push && !full) wr_ptr <= wr_ptr + AW'(1);
            if (len_ok) begin
                lq[lq_wp] <= len_val;
                lq_wp     <= lq_wp + LQW'(1);
            end
            lq_cnt <= lq_cnt + (LQW+1)'(len_ok) - (LQW+1)'(load);
            if (load) begin
                lq_rp  <= lq_rp + LQW'(1);
                rem    <= RW'(words_of_bytes(32'(lq[lq_rp])));
                active <= 1'b1;
            end else if (fire) begin
                rd_ptr <= rd_ptr + AW'(1);
                rem    <= rem - RW'(1);
                if (rem == RW'(1)) active <= 1'b0;
            end
        end
    end

    // R10: a stalled word holds steady
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (past_ok && out_beat.valid && !out_ready) |=>
        (out_beat.valid && $stable(out_beat.data) && $stable(out_beat.last)));

    // R9: after the final word is taken, the next word cannot also be final without a new load
    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (past_ok && fire && out_beat.last) |=> !out_beat.last);
endmodule

// File: rtl/pkt_fifo_bridge.sv
module pkt_fifo_bridge
    import pfb_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int MIN_WORDS = 4,
    parameter int MAX_WORDS = 510,
    parameter int LQ_DEPTH  = 4,
    parameter int LEN_W     = 12,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    beat_t             rx_beat, tx_beat;
    logic [AW-1:0]     occ;
    logic [DATA_W-1:0] rx_head;
    logic              rx_pop, rx_commit;

    assign rx_beat  = '{valid: rx_valid, last: rx_last, data: rx_data};
    assign rx_ready = 1'b1;
    assign rx_pop   = reg_rd && (reg_addr == OFS_RX_WORD);

    pfb_rx #(.DEPTH(DEPTH), .MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS)) rx_i (
        .clk    (clk),
        .rst    (rst),
        .in_beat(rx_beat),
        .pop    (rx_pop),
        .occ    (occ),
        .head   (rx_head),
        .commit (rx_commit)
    );

    pfb_tx #(.DEPTH(DEPTH), .LQ_DEPTH(LQ_DEPTH), .LEN_W(LEN_W)) tx_i (
        .clk      (clk),
        .rst      (rst),
        .push     (reg_wr && (reg_addr == OFS_TX_WORD)),
        .push_data(reg_wdata),
        .len_wr   (reg_wr && (reg_addr == OFS_TX_LEN)),
        .len_val  (reg_wdata[LEN_W-1:0]),
        .out_beat (tx_beat),
        .out_ready(tx_ready)
    );

    assign tx_valid = tx_beat.valid;
    assign tx_data  = tx_beat.data;
    assign tx_last  = tx_beat.last;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                OFS_RX_OCC:  reg_rdata = DATA_W'(occ);
                OFS_RX_WORD: reg_rdata = (occ != '0) ? rx_head : '0;
                default:     reg_rdata = '0;
            endcase
        end
    end

    // R5: the read port returns zero while nothing is committed
    a_r5_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && occ == '0) |-> (reg_rdata == '0));

    // R2: the occupancy register never carries bits above the count field
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_RX_OCC) |-> (reg_rdata[DATA_W-1:AW] == '0));

    // R12: receive words are always accepted
    a_r12_no_stall: assert property (@(posedge clk) disable iff (rst) rx_ready);

    // R3: a commit is the only way the count can grow, so it needs a last word
    a_r3_commit_needs_last: assert property (@(posedge clk) disable iff (rst)
        rx_commit |-> (rx_valid && rx_last));
endmodule

// File: tb/pkt_fifo_bridge_tb_top.sv
module pkt_fifo_bridge_tb_top;
    import pfb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic rx_valid = 0, rx_last = 0, rx_ready;
    logic [31:0] rx_data = '0;
    logic tx_valid, tx_last, tx_ready = 0;
    logic [31:0] tx_data;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] mq [0:2047];
    int mq_head = 0, mq_tail = 0;
    logic [31:0] txw [0:1023];

    always #5 clk = ~clk;

    pkt_fifo_bridge dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    function automatic int exp_words(input int nbytes);
        return (nbytes + 3) / 4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // combinational peek of the occupancy register inside the low clock phase
    task automatic peek_occ(output logic [31:0] v);
        reg_rd = 1; reg_addr = 8'h1C;
        #1 v = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 0;
    endtask

    task automatic send_rx(input int n, input bit keep);
        logic [31:0] pre, v, w;
        @(negedge clk);
        peek_occ(pre);
        for (int i = 0; i < n; i++) begin
            if (i != 0) @(negedge clk);
            w = $urandom;
            rx_valid = 1; rx_data = w; rx_last = (i == n - 1);
            if (keep) begin mq[mq_tail % 2048] = w; mq_tail++; end
            if (i == n - 1) begin
                peek_occ(v);
                chk(v == pre, "R3 occupancy steady before last", v, pre);
            end
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0;
        peek_occ(v);
        if (keep) chk(v == pre + n, "R3 occupancy after commit", v, pre + n);
        else if (n < 4) chk(v == pre, "R6 short packet dropped", v, pre);
        else chk(v == pre, "R7 oversize packet dropped", v, pre);
    endtask

    task automatic drain_rx();
        logic [31:0] v, o;
        while (mq_head != mq_tail) begin
            peek_occ(o);
            bus_read(8'h20, v);
            chk(v == mq[mq_head % 2048], "R4 read word order", v, mq[mq_head % 2048]);
            mq_head++;
            @(negedge clk);
            peek_occ(v);
            chk(v == o - 1, "R4 occupancy decrement", v, o - 1);
        end
    endtask

    task automatic send_tx(input int nbytes, input int pre_words);
        int nw, got;
        logic [31:0] held;
        bit stalled;
        nw = exp_words(nbytes);
        for (int i = pre_words; i < nw; i++) begin
            txw[i] = $urandom;
            bus_write(8'h10, txw[i]);
        end
        repeat (3) begin
            @(negedge clk); #1;
            chk(!tx_valid, "R8 no send before length", {31'd0, tx_valid}, 0);
        end
        bus_write(8'h14, nbytes);
        got = 0; stalled = 0; held = '0;
        for (int c = 0; c < 4000 && got < nw; c++) begin
            @(negedge clk);
            tx_ready = ($urandom % 3) != 0;
            #1;
            if (stalled) chk(tx_valid && tx_data == held, "R10 hold while stalled", tx_data, held);
            stalled = tx_valid && !tx_ready;
            held = tx_data;
            if (tx_valid && tx_ready) begin
                chk(tx_data == txw[got], "R9 transmit word", tx_data, txw[got]);
                chk(tx_last == (got == nw - 1), "R9 last flag", {31'd0, tx_last}, {31'd0, got == nw - 1});
                got++;
            end
        end
        chk(got == nw, "R9 word count", got, nw);
        @(negedge clk); tx_ready = 0;
        repeat (2) @(negedge clk);
        #1 chk(!tx_valid, "R9 idle after packet", {31'd0, tx_valid}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        peek_occ(v);
        chk(v == 0, "R1 occupancy after reset", v, 0);
        chk(!tx_valid, "R1 tx idle after reset", {31'd0, tx_valid}, 0);
        chk(rx_ready, "R12 rx_ready high", {31'd0, rx_ready}, 1);

        // R5: empty read
        bus_read(8'h20, v);
        chk(v == 0, "R5 empty read returns zero", v, 0);
        @(negedge clk); peek_occ(v);
        chk(v == 0, "R5 empty read keeps occupancy", v, 0);

        // R3 R4: random packets, one and two at a time
        for (int k = 0; k < 5; k++) begin
            send_rx(4 + ($urandom % 17), 1);
            if (k % 2 == 1) send_rx(4 + ($urandom % 9), 1);
            drain_rx();
        end

        // R6: short packets between good ones
        send_rx(5, 1);
        send_rx(3, 0);
        send_rx(1, 0);
        send_rx(4, 1);
        drain_rx();

        // R2 R7: fill, overflow, oversize
        send_rx(510, 1);
        bus_read(8'h1C, v);
        chk(v == 510, "R2 occupancy field value", v, 510);
        chk(v[31:9] == 0, "R2 upper bits zero", v, 0);
        send_rx(4, 0);
        drain_rx();
        send_rx(511, 0);
        send_rx(6, 1);
        drain_rx();
        bus_read(8'h20, v);
        chk(v == 0, "R5 read after drain returns zero", v, 0);

        // R8 R9 R10: random transmit lengths
        for (int k = 0; k < 6; k++) send_tx(1 + ($urandom % 60), 0);
        send_tx(4, 0);
        send_tx(13, 0);

        // R11: zero length sends nothing, later length sends queued words
        txw[0] = $urandom; bus_write(8'h10, txw[0]);
        txw[1] = $urandom; bus_write(8'h10, txw[1]);
        bus_write(8'h14, 0);
        repeat (4) @(negedge clk);
        tx_ready = 1;
        #1 chk(!tx_valid, "R11 zero length sends nothing", {31'd0, tx_valid}, 0);
        tx_ready = 0;
        send_tx(8, 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule